// File: doc/BRIEF.md
# Programmable serial bit-rate tick generator

This block produces the timing strobes for a serial port that runs either asynchronously (start/stop framing) or as a synchronous master that drives its own shift clock. A single 8-bit period value `N` sets the reload of a free-running down-counter. The same value gives a different bit rate depending on the selected mode. In asynchronous mode a speed-select input switches between a coarse and a fine divide chain. In synchronous mode that input is ignored. The transmitter and receiver of the port share the generated rate.

Inside, the block is a chain of three stages. A clock prescaler divides by 4 or by 1. The reloadable `N+1` timer follows it. Last comes a by-16 post-divider, which is bypassed in synchronous mode. Each expiry of the timer in asynchronous mode is a receiver sample strobe, so a sample strobe comes 16 times per bit. The wrap of the post-divider, or the timer expiry itself in synchronous mode, is the bit strobe. Both strobes are registered, one-cycle pulses. Any change of the period value, of the mode, or of the speed select while asynchronous restarts the whole chain from its reset state.

Top module: `baud_rate_gen`

## Requirements
- R1: While `rst` is high, both `bit_tick` and `sample_tick` stay low and the timer holds the current `period`. The first tick after release comes exactly one full period later: with release before clock edge 1, the first `bit_tick` is visible after edge P, where P is the bit period in clocks.
- R2: With `sync_mode`=0 and `hi_speed`=0, `bit_tick` pulses once every 64·(N+1) clock cycles.
- R3: With `sync_mode`=0 and `hi_speed`=1, `bit_tick` pulses once every 16·(N+1) clock cycles.
- R4: With `sync_mode`=1, `bit_tick` pulses once every 4·(N+1) clock cycles. Toggling `hi_speed` in this mode has no effect on the tick train.
- R5: With `sync_mode`=0, `sample_tick` pulses every (N+1) cycles when `hi_speed`=1 and every 4·(N+1) cycles when `hi_speed`=0. Every `bit_tick` coincides with a `sample_tick`.
- R6: With `sync_mode`=1, `sample_tick` stays low.
- R7: A change of `period`, of `sync_mode`, or of `hi_speed` while `sync_mode`=0 is seen at the next clock edge R. No tick is issued at R. The tick trains then restart as if from reset, so the next `bit_tick` follows edge R + P.
- R8: `bit_tick` is never high in two consecutive cycles.
- R9: `period`=0 is the fastest setting. The result is a `bit_tick` every 4 cycles in synchronous mode, and a `sample_tick` every cycle with a `bit_tick` every 16 cycles in asynchronous fine mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period | input | CNT_W (8) | Timer reload value N |
| sync_mode | input | 1 | 1 = synchronous master, 0 = asynchronous |
| hi_speed | input | 1 | Asynchronous fine (1) or coarse (0) divide; ignored when synchronous |
| bit_tick | output | 1 | One-cycle bit-rate strobe |
| sample_tick | output | 1 | One-cycle receiver sample strobe, asynchronous mode only |

## Verification
Counting from the edge that ends reset or applies a configuration change as edge 0, the k-th bit strobe is visible just after edge k·P. The k-th sample strobe is visible after edge k·S, where S is P/16. Every output is registered, so the first tick lands on edge P, with no extra delay. The bench changes inputs and samples outputs on the falling edge. It numbers each rising edge since the stimulus and compares every cycle of both strobe trains with the arithmetic prediction over two full bit periods. The offset is 0 after reset release and 1 after a configuration change, because the change itself consumes the edge on which it is seen.

// File: rtl/baud_rate_pkg.sv
package baud_rate_pkg;

   // Selected divide chain; derived from mode and speed inputs.
   typedef enum logic [1:0] {
      RATE_SYNC       = 2'd0,
      RATE_ASYNC_SLOW = 2'd1,
      RATE_ASYNC_FAST = 2'd2
   } rate_sel_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler
   import baud_rate_pkg::*;
#(
   parameter int unsigned SYNC_DIV = 4,
   parameter int unsigned SLOW_DIV = 4
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      clr,
   input  rate_sel_e sel,
   output logic      en
);

   localparam int unsigned MAX_DIV = max2(SYNC_DIV, SLOW_DIV);
   localparam int unsigned PW      = $clog2(MAX_DIV + 1);

   logic [PW-1:0] div;
   logic [PW-1:0] cnt;

   generate
      if (SYNC_DIV == SLOW_DIV) begin : g_shared_div
         always_comb div = (sel == RATE_ASYNC_FAST) ? PW'(1) : PW'(SYNC_DIV);
      end else begin : g_split_div
         always_comb begin
            case (sel)
               RATE_SYNC:       div = PW'(SYNC_DIV);
               RATE_ASYNC_SLOW: div = PW'(SLOW_DIV);
               default:         div = PW'(1);
            endcase
         end
      end
   endgenerate

   assign en = (cnt == div - PW'(1));

   always_ff @(posedge clk) begin
      if (rst || clr)  cnt <= '0;
      else if (en)     cnt <= '0;
      else             cnt <= cnt + PW'(1);
   end

endmodule

// File: rtl/baud_timer.sv
module baud_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             en,
   input  logic [CNT_W-1:0] reload,
   output logic             expire
);

   logic [CNT_W-1:0] cnt;

   assign expire = en && (cnt == '0);

   always_ff @(posedge clk) begin
      if (rst || clr)   cnt <= reload;
      else if (expire)  cnt <= reload;
      else if (en)      cnt <= cnt - CNT_W'(1);
   end

endmodule

// File: rtl/baud_postdiv.sv
module baud_postdiv #(
   parameter int unsigned OVS = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic en,
   input  logic bypass,
   output logic wrap
);

   localparam int unsigned OW = $clog2(OVS);

   logic [OW-1:0] cnt;
   logic          last;

   assign last = (cnt == OW'(OVS - 1));
   assign wrap = en && (bypass || last);

   always_ff @(posedge clk) begin
      if (rst || clr)           cnt <= '0;
      else if (en && !bypass)   cnt <= last ? '0 : cnt + OW'(1);
   end

endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
   import baud_rate_pkg::*;
#(
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned SYNC_DIV = 4,
   parameter int unsigned SLOW_DIV = 4,
   parameter int unsigned OVS      = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] period,
   input  logic             sync_mode,
   input  logic             hi_speed,
   output logic             bit_tick,
   output logic             sample_tick
);

   // Elaboration-time parameter checks
   if (CNT_W < 1)    begin : g_bad_cnt_w  $error("CNT_W must be at least 1");    end
   if (SYNC_DIV < 2) begin : g_bad_sync   $error("SYNC_DIV must be at least 2"); end
   if (SLOW_DIV < 2) begin : g_bad_slow   $error("SLOW_DIV must be at least 2"); end
   if (OVS < 2)      begin : g_bad_ovs    $error("OVS must be at least 2");      end

   rate_sel_e        sel, sel_q;
   logic [CNT_W-1:0] period_q;
   logic             restart;
   logic             pre_en;
   logic             expire;
   logic             wrap;

   always_comb begin
      if (sync_mode)      sel = RATE_SYNC;
      else if (hi_speed)  sel = RATE_ASYNC_FAST;
      else                sel = RATE_ASYNC_SLOW;
   end

   // Any change of the effective configuration restarts the chain.
   assign restart = (period != period_q) || (sel != sel_q);

   always_ff @(posedge clk) begin
      period_q <= period;
      sel_q    <= sel;
      if (rst || restart) begin
         bit_tick    <= 1'b0;
         sample_tick <= 1'b0;
      end else begin
         bit_tick    <= wrap;
         sample_tick <= expire && (sel != RATE_SYNC);
      end
   end

   baud_prescaler #(
      .SYNC_DIV (SYNC_DIV),
      .SLOW_DIV (SLOW_DIV)
   ) u_pre (
      .clk (clk),
      .rst (rst),
      .clr (restart),
      .sel (sel),
      .en  (pre_en)
   );

   baud_timer #(
      .CNT_W (CNT_W)
   ) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .clr    (restart),
      .en     (pre_en),
      .reload (period),
      .expire (expire)
   );

   baud_postdiv #(
      .OVS (OVS)
   ) u_post (
      .clk    (clk),
      .rst    (rst),
      .clr    (restart),
      .en     (expire),
      .bypass (sel == RATE_SYNC),
      .wrap   (wrap)
   );

endmodule

// File: rtl/baud_rate_gen_chk.sv
module baud_rate_gen_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic [CNT_W-1:0] period,
   input logic             sync_mode,
   input logic             bit_tick,
   input logic             sample_tick
);

   // R1
   no_tick_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!bit_tick && !sample_tick));

   // R6
   no_sample_in_sync_chk: assert property (@(posedge clk) disable iff (rst)
      $past(sync_mode) |-> !sample_tick);

   // R5
   bit_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
      (bit_tick && !$past(sync_mode)) |-> sample_tick);

   // R8
   bit_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
      bit_tick |=> !bit_tick);

   // R7
   restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (period != $past(period)) |=> (!bit_tick && !sample_tick));

endmodule

bind baud_rate_gen baud_rate_gen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .period      (period),
   .sync_mode   (sync_mode),
   .bit_tick    (bit_tick),
   .sample_tick (sample_tick)
);

// File: tb/baud_rate_gen_tb.sv
`timescale 1ns/1ps
module baud_rate_gen_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] period = 8'd0;
   logic       sync_mode = 1'b1;
   logic       hi_speed = 1'b0;
   logic       bit_tick;
   logic       sample_tick;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   baud_rate_gen u_dut (
      .clk         (clk),
      .rst         (rst),
      .period      (period),
      .sync_mode   (sync_mode),
      .hi_speed    (hi_speed),
      .bit_tick    (bit_tick),
      .sample_tick (sample_tick)
   );

   function automatic int bit_per(input int n, input bit sm, input bit hs);
      if (sm)       return 4 * (n + 1);
      else if (hs)  return 16 * (n + 1);
      else          return 64 * (n + 1);
   endfunction

   // Compare both strobes every cycle; expected high when c > base and (c-base)%P == 0.
   task automatic check_stream(input int pb, input int ps, input bit async_m,
                               input int base, input int ncyc, input bit toggle,
                               input string btag, input string stag);
      int  bbad = 0, sbad = 0, bc = 0, sc = 0;
      bit  bact = 0, bexp = 0, sact = 0, sexp = 0;
      for (int c = 1; c <= ncyc; c++) begin
         bit eb, es;
         @(posedge clk);
         @(negedge clk);
         eb = (c > base) && (((c - base) % pb) == 0);
         es = async_m && (c > base) && (((c - base) % ps) == 0);
         if (bit_tick !== eb) begin
            if (bbad == 0) begin bc = c; bact = bit_tick; bexp = eb; end
            bbad++;
         end
         if (sample_tick !== es) begin
            if (sbad == 0) begin sc = c; sact = sample_tick; sexp = es; end
            sbad++;
         end
         if (toggle) hi_speed = ~hi_speed;
      end
      checks += 2;
      if (bbad != 0) begin
         fails++;
         $display("FAIL %s bit_tick period=%0d cycle %0d: actual %0b expected %0b",
                  btag, period, bc, bact, bexp);
      end
      if (sbad != 0) begin
         fails++;
         $display("FAIL %s sample_tick period=%0d cycle %0d: actual %0b expected %0b",
                  stag, period, sc, sact, sexp);
      end
   endtask

   task automatic run_cfg(input int n, input bit sm, input bit hs);
      int    pb = bit_per(n, sm, hs);
      string bt, st;
      @(negedge clk);
      rst = 1'b1; period = 8'(n); sync_mode = sm; hi_speed = hs;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      if (n == 0)   bt = "R9/R8";
      else if (sm)  bt = "R4/R8";
      else if (hs)  bt = "R3/R8";
      else          bt = "R2/R8";
      st = sm ? "R6" : ((n == 0) ? "R9/R5" : "R5");
      check_stream(pb, pb / 16, !sm, 0, 2 * pb + 2, sm, bt, st);
   endtask

   initial begin
      // R1: ticks stay low while reset is held, even at the fastest setting
      begin
         int bad = 0;
         for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (bit_tick !== 1'b0 || sample_tick !== 1'b0) bad++;
         end
         checks++;
         if (bad != 0) begin
            fails++;
            $display("FAIL R1 ticks during reset: actual %0b/%0b expected 0/0",
                     bit_tick, sample_tick);
         end
      end

      // R1..R6, R8, R9: small-period sweep over all three modes
      for (int n = 0; n < 16; n++) begin
         run_cfg(n, 1'b1, 1'b0);
         run_cfg(n, 1'b0, 1'b1);
         run_cfg(n, 1'b0, 1'b0);
      end
      // Largest period in every mode
      run_cfg(255, 1'b1, 1'b0);
      run_cfg(255, 1'b0, 1'b1);
      run_cfg(255, 1'b0, 1'b0);

      // R7: restarts on live configuration changes
      run_cfg(3, 1'b0, 1'b1);
      period = 8'd9;
      check_stream(160, 10, 1'b1, 1, 322, 1'b0, "R7", "R7");
      hi_speed = 1'b0;
      check_stream(640, 40, 1'b1, 1, 1282, 1'b0, "R7", "R7");
      sync_mode = 1'b1;
      check_stream(40, 40, 1'b0, 1, 82, 1'b1, "R7", "R7");
      sync_mode = 1'b0; hi_speed = 1'b1;
      check_stream(160, 10, 1'b1, 1, 322, 1'b0, "R7", "R7");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(190000 * 8);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule